// File: doc/BRIEF.md
# Manchester Telegram Receiver

This block recovers telegrams that field devices send back on a shared two-wire bus. It takes the sliced line level and a two-bit rate code. It makes its own sample tick and waits for the line to be quiet for long enough. It then locks onto the first rising level and decodes each bit from the centres of its two half-bit cells. The first two bits must carry the upstream direction marker 0 then 1.

Two upstream layouts exist, and `kind_i` picks one when a telegram starts. A short result telegram holds an 11-bit data field. A longer readout telegram holds a 5-bit register number and a 16-bit data word. In both layouts a 10-bit parity trailer follows the fields. When a telegram ends, the receiver gives a one-cycle completion pulse, the decoded fields and four error flags. A saturating counter of bad telegrams lets the host judge how healthy the bus is.

Top module: `mrx_telegram_rx`

## Requirements
- R1: One sample tick occurs every 8, 4, 2 or 1 clocks for `rate_i` = 00, 01, 10 or 11. One bit period lasts 8 ticks, and each half-bit cell lasts 4 ticks.
- R2: A telegram starts only on a tick with the line high that follows at least 16 consecutive low ticks. A high level after a shorter quiet gap is ignored: it gives no completion pulse and does not change the error counter.
- R3: A bit of value 0 is sent high-then-low and a bit of value 1 low-then-high. The first payload bit sent is payload index 0.
- R4: The first two bits must be 0 then 1. Any other pair sets `flags_o[2]` (start error).
- R5: `kind_i` is sampled at the start. With `kind_i`=0 the telegram is 2 + 11 + 10 bits, `data_o[10:0]` takes payload bits 0..10, and the upper bits and `reg_o` are zero. With `kind_i`=1 it is 2 + 21 + 10 bits, `reg_o` takes payload bits 0..4 and `data_o` takes payload bits 5..20.
- R6: Trailer bit j must equal the XOR of every payload bit whose index modulo 10 equals j. A mismatch sets `flags_o[1]`.
- R7: A bit whose two half-cells are equal sets `flags_o[0]` (coding error). The bit is then taken as the second half-cell level.
- R8: If the line stays low for 16 consecutive ticks inside a telegram, the telegram ends early and `flags_o[3]` (abort) is set.
- R9: Each telegram ends with `done_o` high for exactly one cycle. `flags_o` is zero outside that cycle. `err_o` is high in that cycle exactly when some flag is set.
- R10: `err_cnt_o` rises by one for each telegram that ends with `err_o`, and holds at its all-ones value. `err_clr_i` zeroes it on the next clock and overrides an increment.
- R11: After reset, `done_o`, `err_o`, `flags_o`, `reg_o`, `data_o` and `err_cnt_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Sliced bus line level |
| rate_i | input | 2 | Rate code, selects clocks per sample tick |
| kind_i | input | 1 | Expected layout: 0 result, 1 register readout |
| err_clr_i | input | 1 | Clears the error counter |
| done_o | output | 1 | One-cycle end-of-telegram pulse |
| err_o | output | 1 | Telegram ended with at least one error |
| flags_o | output | 4 | {abort, start, parity, coding} |
| reg_o | output | 5 | Register number of the last readout telegram |
| data_o | output | 16 | Data field of the last telegram |
| err_cnt_o | output | ERRC_W | Saturating count of bad telegrams |

## Verification
The bench builds the receiver with the defaults of 8 samples per bit and a 2-bit quiet gap. It sets `ERRC_W` to 3, so the counter saturates at 7 and that ceiling is reached after only a few corrupted telegrams. Telegrams are sent at all four rate codes, so each tick divider is exercised against real frame timing. Both layouts are sent clean and with a flipped trailer bit, a broken half-cell pair or a wrong start pair. Directed tests cover a too-short quiet gap and a line that drops out mid-telegram.

// File: rtl/mrx_pkg.sv
`timescale 1ns/1ps
// Shared layout constants, state type and trailer computation for the
// telegram receiver. Assumes trailer length 10 and payloads of 11 or 21 bits.
package mrx_pkg;
    localparam int START_BITS = 2;
    localparam int RES_BITS   = 11;
    localparam int RDO_BITS   = 21;
    localparam int PAR_BITS   = 10;
    localparam int REG_BITS   = 5;

    typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_DONE} rx_state_t;

    // Trailer bit j is the XOR of payload bits whose index mod PAR_BITS is j.
    function automatic logic [PAR_BITS-1:0] calc_trailer(
        input logic [RDO_BITS-1:0] pay,
        input logic                is_rdo
    );
        logic [PAR_BITS-1:0] acc;
        acc = '0;
        for (int i = 0; i < RDO_BITS; i++) begin
            if (is_rdo || (i < RES_BITS)) begin
                acc[i % PAR_BITS] = acc[i % PAR_BITS] ^ pay[i];
            end
        end
        return acc;
    endfunction
endpackage

// File: rtl/mrx_tick_gen.sv
`timescale 1ns/1ps
// Sample tick generator: one tick every (DIV_MAX >> rate_i) clocks.
// Assumes DIV_MAX is a power of two of at least 8 for the 2-bit rate code.
module mrx_tick_gen #(
    parameter int DIV_MAX = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_i,
    output logic       tick_o
);
    localparam int CW = $clog2(DIV_MAX);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    // Terminal count for the selected rate.
    always_comb lim = CW'((DIV_MAX >> rate_i) - 1);

    // Free-running divider, wraps at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q >= lim) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q >= lim);
endmodule

// File: rtl/mrx_frame_rx.sv
`timescale 1ns/1ps
// Telegram framer and Manchester decoder. It tracks the quiet time, locks on
// the first rising level after a full gap, samples each half-cell at its
// centre and collects start, payload and trailer bits. It reports the result
// one cycle after the last bit. Assumes SPB is a multiple of 4.
module mrx_frame_rx
    import mrx_pkg::*;
#(
    parameter int SPB       = 8,
    parameter int IDLE_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                line_i,
    input  logic                kind_i,
    output logic                done_o,
    output logic [3:0]          flags_o,
    output logic [REG_BITS-1:0] reg_o,
    output logic [15:0]         data_o
);
    localparam int HALF       = SPB / 2;
    localparam int MID        = HALF / 2;
    localparam int IDLE_TICKS = IDLE_BITS * SPB;
    localparam int RW         = $clog2(IDLE_TICKS + 1);
    localparam int PW         = $clog2(HALF);
    localparam int BW         = 6;

    rx_state_t             st_q;
    logic [RW-1:0]         run_q;
    logic [PW-1:0]         pos_q, pos_nx;
    logic                  half_q, first_q, kind_q;
    logic [BW-1:0]         bitn_q, p_idx, q_idx, paylen, total;
    logic [RDO_BITS-1:0]   pay_q;
    logic [PAR_BITS-1:0]   par_q, par_calc;
    logic                  f_code, f_start, f_abort;

    // Layout-dependent lengths and write indices.
    always_comb begin
        paylen   = kind_q ? BW'(RDO_BITS) : BW'(RES_BITS);
        total    = paylen + BW'(START_BITS + PAR_BITS);
        p_idx    = bitn_q - BW'(START_BITS);
        q_idx    = p_idx - paylen;
        pos_nx   = (pos_q == PW'(HALF - 1)) ? '0 : pos_q + 1'b1;
        par_calc = calc_trailer(pay_q, kind_q);
    end

    // Count consecutive low ticks, saturating at the quiet-gap length.
    always_ff @(posedge clk) begin
        if (!rst_n)                          run_q <= '0;
        else if (tick_i && line_i)           run_q <= '0;
        else if (tick_i && run_q != RW'(IDLE_TICKS)) run_q <= run_q + 1'b1;
    end

    // Frame sequencing, half-cell decoding and result reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RX_IDLE; pos_q <= '0; half_q <= 1'b0; first_q <= 1'b0;
            kind_q <= 1'b0; bitn_q <= '0; pay_q <= '0; par_q <= '0;
            f_code <= 1'b0; f_start <= 1'b0; f_abort <= 1'b0;
            done_o <= 1'b0; flags_o <= '0; reg_o <= '0; data_o <= '0;
        end else begin
            done_o  <= 1'b0;
            flags_o <= '0;
            case (st_q)
                RX_IDLE: begin
                    if (tick_i && line_i && run_q == RW'(IDLE_TICKS)) begin
                        st_q <= RX_BITS; pos_q <= '0; half_q <= 1'b0;
                        bitn_q <= '0; kind_q <= kind_i; pay_q <= '0; par_q <= '0;
                        f_code <= 1'b0; f_start <= 1'b0; f_abort <= 1'b0;
                    end
                end
                RX_BITS: begin
                    if (tick_i) begin
                        if (!line_i && run_q == RW'(IDLE_TICKS - 1)) begin
                            f_abort <= 1'b1;
                            st_q    <= RX_DONE;
                        end else begin
                            pos_q <= pos_nx;
                            if (pos_nx == PW'(MID)) begin
                                if (!half_q) begin
                                    first_q <= line_i;
                                    half_q  <= 1'b1;
                                end else begin
                                    half_q <= 1'b0;
                                    if (line_i == first_q) f_code <= 1'b1;
                                    if (bitn_q < BW'(START_BITS)) begin
                                        if (line_i != bitn_q[0]) f_start <= 1'b1;
                                    end else if (p_idx < paylen) begin
                                        pay_q[p_idx[4:0]] <= line_i;
                                    end else begin
                                        par_q[q_idx[3:0]] <= line_i;
                                    end
                                    bitn_q <= bitn_q + 1'b1;
                                    if (bitn_q == total - 1'b1) st_q <= RX_DONE;
                                end
                            end
                        end
                    end
                end
                default: begin
                    done_o  <= 1'b1;
                    flags_o <= {f_abort, f_start, (!f_abort && par_calc != par_q), f_code};
                    reg_o   <= kind_q ? pay_q[REG_BITS-1:0] : '0;
                    data_o  <= kind_q ? pay_q[RDO_BITS-1:REG_BITS]
                                      : {5'b0, pay_q[RES_BITS-1:0]};
                    st_q    <= RX_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/mrx_err_count.sv
`timescale 1ns/1ps
// Saturating counter of bad telegrams; a clear has priority over a step.
module mrx_err_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    // Step once per bad telegram, hold at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)            cnt_o <= '0;
        else if (inc_i && !(&cnt_o))    cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/mrx_telegram_rx.sv
`timescale 1ns/1ps
// Top of the upstream telegram receiver: tick divider, framer/decoder and
// error counter. Assumes the line is already sliced to one bit.
module mrx_telegram_rx #(
    parameter int SPB       = 8,
    parameter int IDLE_BITS = 2,
    parameter int ERRC_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    input  logic [1:0]        rate_i,
    input  logic              kind_i,
    input  logic              err_clr_i,
    output logic              done_o,
    output logic              err_o,
    output logic [3:0]        flags_o,
    output logic [4:0]        reg_o,
    output logic [15:0]       data_o,
    output logic [ERRC_W-1:0] err_cnt_o
);
    localparam int DIV_MAX = 8;

    logic tick;

    mrx_tick_gen #(.DIV_MAX(DIV_MAX)) tick_i (
        .clk(clk), .rst_n(rst_n), .rate_i(rate_i), .tick_o(tick)
    );

    mrx_frame_rx #(.SPB(SPB), .IDLE_BITS(IDLE_BITS)) frame_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .line_i(line_i),
        .kind_i(kind_i), .done_o(done_o), .flags_o(flags_o),
        .reg_o(reg_o), .data_o(data_o)
    );

    assign err_o = done_o && (flags_o != 4'b0);

    mrx_err_count #(.W(ERRC_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .clr_i(err_clr_i), .inc_i(err_o),
        .cnt_o(err_cnt_o)
    );
endmodule

// File: rtl/mrx_telegram_rx_chk.sv
`timescale 1ns/1ps
// Port-level properties of the receiver, attached with bind.
module mrx_telegram_rx_chk #(
    parameter int ERRC_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              err_clr_i,
    input logic              done_o,
    input logic              err_o,
    input logic [3:0]        flags_o,
    input logic [ERRC_W-1:0] err_cnt_o
);
    localparam logic [ERRC_W-1:0] CMAX = '1;

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_flags_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> flags_o == 4'b0);

    assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_clr_i && !(done_o && err_o)) |=> $stable(err_cnt_o));

    assert_cnt_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr_i |=> err_cnt_o == '0);

    assert_cnt_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_clr_i && err_cnt_o == CMAX) |=> err_cnt_o == CMAX);

    assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_clr_i && done_o && err_o && err_cnt_o != CMAX)
            |=> err_cnt_o == $past(err_cnt_o) + 1'b1);
endmodule

bind mrx_telegram_rx mrx_telegram_rx_chk #(.ERRC_W(ERRC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .err_clr_i(err_clr_i), .done_o(done_o),
    .err_o(err_o), .flags_o(flags_o), .err_cnt_o(err_cnt_o)
);

// File: tb/mrx_telegram_rx_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: vector table of telegrams, then directed cases.
module mrx_telegram_rx_tb_top;
    localparam int EW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_i = 1'b0;
    logic [1:0]    rate_i = 2'd3;
    logic          kind_i = 1'b0;
    logic          err_clr_i = 1'b0;
    logic          done_o, err_o;
    logic [3:0]    flags_o;
    logic [4:0]    reg_o;
    logic [15:0]   data_o;
    logic [EW-1:0] err_cnt_o;

    always #10 clk = ~clk;

    mrx_telegram_rx #(.ERRC_W(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .rate_i(rate_i),
        .kind_i(kind_i), .err_clr_i(err_clr_i), .done_o(done_o),
        .err_o(err_o), .flags_o(flags_o), .reg_o(reg_o), .data_o(data_o),
        .err_cnt_o(err_cnt_o)
    );

    int checks = 0, errors = 0, div = 1, ndone = 0, ecnt = 0;
    logic [3:0]  g_flags = '0;
    logic        g_err = 1'b0;
    logic [4:0]  g_reg = '0;
    logic [15:0] g_data = '0;

    // Capture each completion away from the active edge.
    always @(negedge clk) begin
        if (done_o) begin
            ndone   <= ndone + 1;
            g_flags <= flags_o;
            g_err   <= err_o;
            g_reg   <= reg_o;
            g_data  <= data_o;
        end
    end

    // {rate[25:24], kind[23], payload[22:2], corrupt[1:0]}
    // corrupt: 0 none, 1 flip trailer bit 3, 2 bad first payload cell pair, 3 start pair 00
    localparam logic [25:0] VEC [6] = '{
        {2'd3, 1'b0, 21'h0005A5, 2'd0},
        {2'd3, 1'b1, 21'h1ABCDE, 2'd0},
        {2'd2, 1'b1, 21'h0F0F0F, 2'd1},
        {2'd1, 1'b0, 21'h000312, 2'd2},
        {2'd0, 1'b1, 21'h012345, 2'd3},
        {2'd0, 1'b0, 21'h0007FF, 2'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n * div) @(negedge clk);
    endtask

    task automatic half_cell(input logic v);
        line_i = v;
        ticks(4);
    endtask

    task automatic send_bit(input logic b);
        if (b) begin half_cell(1'b0); half_cell(1'b1); end
        else   begin half_cell(1'b1); half_cell(1'b0); end
    endtask

    task automatic set_rate(input logic [1:0] r);
        rate_i = r;
        div = 8 >> r;
    endtask

    function automatic logic [9:0] ref_trailer(input logic [20:0] p, input logic k);
        logic [9:0] t = '0;
        for (int i = 0; i < 21; i++)
            if (k || i < 11) t[i % 10] = t[i % 10] ^ p[i];
        return t;
    endfunction

    task automatic send(input logic k, input logic [20:0] p, input logic [1:0] c);
        logic [9:0] t;
        int len;
        t = ref_trailer(p, k);
        len = k ? 21 : 11;
        kind_i = k;
        send_bit(1'b0);
        send_bit(c == 2'd3 ? 1'b0 : 1'b1);
        for (int i = 0; i < len; i++) begin
            if (c == 2'd2 && i == 0) begin half_cell(1'b1); half_cell(1'b1); end
            else send_bit(p[i]);
        end
        for (int j = 0; j < 10; j++) send_bit((c == 2'd1 && j == 3) ? ~t[j] : t[j]);
        line_i = 1'b0;
    endtask

    task automatic note_err(input logic e);
        if (e && ecnt < 7) ecnt++;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 done", done_o, 0);
        check("R11 flags", {err_o, flags_o}, 0);
        check("R11 fields", {reg_o, data_o}, 0);
        check("R11 count", err_cnt_o, 0);

        // Table walk: R1 rates, R3/R5 layouts, R4/R6/R7 faults, R9 pulse
        for (int v = 0; v < 6; v++) begin
            logic [25:0] e;
            logic [3:0]  xf;
            int          snap;
            e = VEC[v];
            set_rate(e[25:24]);
            ticks(24);
            snap = ndone;
            send(e[23], e[22:2], e[1:0]);
            ticks(20);
            case (e[1:0])
                2'd0:    xf = 4'b0000;
                2'd1:    xf = 4'b0010;
                2'd2:    xf = {2'b00, ~e[2], 1'b1};
                default: xf = 4'b0100;
            endcase
            note_err(xf != 0);
            check("R9 one completion", ndone - snap, 1);
            check(e[1:0] == 2'd1 ? "R6 trailer flag" : e[1:0] == 2'd2 ? "R7 coding flag" :
                  e[1:0] == 2'd3 ? "R4 start flag" : "R3 clean flags", g_flags, xf);
            check("R9 err", g_err, xf != 0);
            if (xf == 0) begin
                check("R1 R5 reg field", g_reg, e[23] ? e[6:2] : 5'd0);
                check("R1 R5 data field", g_data, e[23] ? e[22:7] : {5'd0, e[12:2]});
            end
            check("R10 count", err_cnt_o, ecnt);
        end

        // R2: quiet gap of only one bit period; second telegram ignored
        begin
            int snap;
            set_rate(2'd3);
            ticks(24);
            send(1'b0, 21'h000155, 2'd0);
            ticks(8);
            snap = ndone;
            send(1'b1, 21'h0AAAAA, 2'd3);
            ticks(30);
            check("R2 no completion", ndone - snap, 0);
            check("R2 count unchanged", err_cnt_o, ecnt);
        end

        // R8: line drops out mid-telegram
        begin
            int snap;
            ticks(24);
            snap = ndone;
            kind_i = 1'b1;
            send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
            line_i = 1'b0;
            ticks(30);
            check("R8 completion", ndone - snap, 1);
            check("R8 abort flag", g_flags[3], 1);
            check("R8 err", g_err, 1);
            note_err(1'b1);
            check("R10 count after abort", err_cnt_o, ecnt);
        end

        // R10: saturation then clear
        for (int n = 0; n < 4; n++) begin
            ticks(24);
            send(1'b0, 21'h000001, 2'd3);
            ticks(20);
            note_err(1'b1);
        end
        check("R10 saturated", err_cnt_o, 7);
        check("R10 model", ecnt, 7);
        @(negedge clk);
        err_clr_i = 1'b1;
        @(negedge clk);
        err_clr_i = 1'b0;
        check("R10 cleared", err_cnt_o, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule